// File: doc/BRIEF.md
# Cross-Core CPI Estimator

This block predicts how many cycles per instruction a workload would need on the other core type of a two-type multi-core. It takes a profile of the workload taken on the core it runs on now. For the estimate it splits CPI into a base part, which covers everything except memory stalls, and a memory part. The memory part is scaled by an estimated ratio of memory-level parallelism (MLP) between the big and the small core. The base part is either fixed by the big core's issue width or derived from an in-order issue model driven by register dependency distances.

A scheduler loads one profile, pulses `start`, and reads three estimates when `done` pulses. The inputs are the memory CPI, LLC misses per instruction, the MLP measured on the current core, the average dependency distance, and a dependency-distance histogram. The outputs are the estimated base, memory and total CPI. All values are unsigned Q8.8. The two divisions share one sequential divider, so a job takes a few dozen cycles.

Top module: `cce_estimator`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy` and `done` are 0 and all three estimate outputs are 0. A reset asserted during a job discards that job.
- R2: A `start` seen while idle captures every data input and raises `busy` on the next cycle. The job ends with `done` high for exactly one cycle and `busy` low. The outputs change only in the cycle `done` is high. A `start` while busy, and input changes after capture, have no effect.
- R3: With `est_small` = 0 (estimate the big core from a small-core profile), the base estimate is 1/BIG_W in Q8.8. This is 0x0040 for the default width of 4.
- R4: With `est_small` = 0:
  - big-core MLP = `miss_per_instr` × ROB_SIZE, saturated to 0xFFFF;
  - ratio = that value / `mlp_meas`;
  - memory estimate = `mem_cpi` / ratio.
- R5: With `est_small` = 1:
  - small-core MLP = `miss_per_instr` × `dep_dist`, truncated to Q8.8;
  - ratio = `mlp_meas` / small-core MLP;
  - memory estimate = `mem_cpi` × ratio.
- R6: With `est_small` = 1, the base estimate is 1/IPC, and IPC is the sum of i × P[i] for i = 1..4. Here Sk = p1+…+pk. For i < 4, P[i] = (1−S1)…(1−S(i−1)) × Si, and P[4] = (1−S1)(1−S2)(1−S3). `dep_hist` bits [15:0] hold p1 (the probability of distance 1), bits [31:16] hold p2 and bits [47:32] hold p3. Each product is truncated to Q8.8 left to right.
- R7: A factor (1 − Sk) whose Sk is 1.0 or more is taken as zero.
- R8: Every Q8.8 division by zero gives 0xFFFF. Every product or quotient above 0xFFFF saturates to 0xFFFF.
- R9: The total estimate equals the base plus the memory estimate, saturated to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (taken only when idle) |
| est_small | input | 1 | 0: estimate big core from small-core profile; 1: estimate small core from big-core profile |
| mem_cpi | input | 16 | Measured memory CPI component, Q8.8 |
| miss_per_instr | input | 16 | LLC misses per instruction, Q8.8 |
| mlp_meas | input | 16 | MLP measured on the current core, Q8.8 |
| dep_dist | input | 16 | Average dependency distance, Q8.8 |
| dep_hist | input | 48 | Distance probabilities p3,p2,p1 (p1 in low bits), Q8.8 each |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse: estimates updated |
| est_base_cpi | output | 16 | Estimated base CPI, Q8.8 |
| est_mem_cpi | output | 16 | Estimated memory CPI, Q8.8 |
| est_total_cpi | output | 16 | Estimated total CPI, Q8.8 |

## Verification
The bound checker watches the handshake on every cycle:
- `done` lasts exactly one cycle and never overlaps `busy`;
- an idle start always raises `busy`;
- the estimates never move outside a `done` cycle;
- every reported total equals the saturated sum of the reported parts;
- a big-core job always reports the width-derived base.

The arithmetic itself can only be shown by the bench's scenarios. These are hand-worked vectors for both directions: a spread of histograms including one that needs the negative-factor clamp, zero MLP on either side of the ratio, a saturating MLP product and an overflowing total. Directed tests cover a start issued while busy, input changes after capture and a reset in the middle of a job.

// File: rtl/cce_pkg.sv
package cce_pkg;

    localparam int Q_W    = 16;
    localparam int Q_FRAC = 8;

    typedef logic [Q_W-1:0] q_t;

    localparam q_t Q_ONE = q_t'(1) << Q_FRAC;
    localparam q_t Q_MAX = '1;

    // Q8.8 multiply, truncated, saturating
    function automatic q_t q_mul_sat(input q_t a, input q_t b);
        logic [2*Q_W-1:0] prod;
        logic [2*Q_W-1:0] shifted;
        prod    = {{Q_W{1'b0}}, a} * {{Q_W{1'b0}}, b};
        shifted = prod >> Q_FRAC;
        if (|shifted[2*Q_W-1:Q_W]) return Q_MAX;
        return shifted[Q_W-1:0];
    endfunction

    // Q8.8 add, saturating
    function automatic q_t q_add_sat(input q_t a, input q_t b);
        logic [Q_W:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        if (sum[Q_W]) return Q_MAX;
        return sum[Q_W-1:0];
    endfunction

endpackage

// File: rtl/cce_issue_model.sv
// Combinational in-order issue model: expected base IPC from the
// dependency-distance histogram.
module cce_issue_model
    import cce_pkg::*;
#(
    parameter int SMALL_W = 4
) (
    input  logic [(SMALL_W-1)*Q_W-1:0] hist,
    output q_t                         ipc
);
    localparam int BINS  = SMALL_W - 1;
    localparam int ACC_W = Q_W + $clog2(SMALL_W * SMALL_W + 1);

    q_t cum  [BINS];
    q_t comp [BINS];
    q_t pref [SMALL_W];
    q_t prob [SMALL_W];

    assign pref[0] = Q_ONE;

    for (genvar k = 0; k < BINS; k++) begin : g_bin
        if (k == 0) begin : g_first
            assign cum[k] = hist[Q_W-1:0];
        end else begin : g_next
            assign cum[k] = q_add_sat(cum[k-1], hist[k*Q_W +: Q_W]);
        end
        // negative complement clamps to zero
        assign comp[k]   = (cum[k] >= Q_ONE) ? '0 : (Q_ONE - cum[k]);
        assign pref[k+1] = q_mul_sat(pref[k], comp[k]);
        assign prob[k]   = q_mul_sat(pref[k], cum[k]);
    end

    assign prob[SMALL_W-1] = pref[SMALL_W-1];

    logic [ACC_W-1:0] acc;
    always_comb begin
        acc = '0;
        for (int k = 0; k < SMALL_W; k++) begin
            acc = acc + ACC_W'(k + 1) * ACC_W'(prob[k]);
        end
        ipc = (|acc[ACC_W-1:Q_W]) ? Q_MAX : acc[Q_W-1:0];
    end

endmodule

// File: rtl/cce_divider.sv
// Sequential restoring Q8.8 divider: quot = (num << FRAC) / den, saturating.
module cce_divider
    import cce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  q_t   num,
    input  q_t   den,
    output logic done,
    output q_t   quot
);
    localparam int DVD_W = Q_W + Q_FRAC;
    localparam int CNT_W = $clog2(DVD_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        q_t               rem;
        logic [DVD_W-1:0] dq;
        q_t               den;
        logic             done;
        q_t               quot;
    } div_st_t;

    div_st_t st_d, st_q;

    logic [Q_W:0]     trial;
    logic             qbit;
    logic [DVD_W-1:0] dq_next;
    q_t               rem_next;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = {st_q.rem, st_q.dq[DVD_W-1]};
        qbit      = (trial >= {1'b0, st_q.den});
        rem_next  = qbit ? q_t'(trial - {1'b0, st_q.den}) : trial[Q_W-1:0];
        dq_next   = {st_q.dq[DVD_W-2:0], qbit};
        if (start && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.rem  = '0;
            st_d.dq   = {num, {Q_FRAC{1'b0}}};
            st_d.den  = den;
        end else if (st_q.busy) begin
            st_d.rem = rem_next;
            st_d.dq  = dq_next;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(DVD_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.quot = (|dq_next[DVD_W-1:Q_W]) ? Q_MAX : dq_next[Q_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign quot = st_q.quot;

endmodule

// File: rtl/cce_estimator.sv
// Cross-core CPI estimator top.
module cce_estimator
    import cce_pkg::*;
#(
    parameter int ROB_SIZE = 128,
    parameter int BIG_W    = 4,
    parameter int SMALL_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        est_small,
    input  logic [15:0]                 mem_cpi,
    input  logic [15:0]                 miss_per_instr,
    input  logic [15:0]                 mlp_meas,
    input  logic [15:0]                 dep_dist,
    input  logic [(SMALL_W-1)*16-1:0]   dep_hist,
    output logic                        busy,
    output logic                        done,
    output logic [15:0]                 est_base_cpi,
    output logic [15:0]                 est_mem_cpi,
    output logic [15:0]                 est_total_cpi
);
    localparam int HIST_W = (SMALL_W - 1) * Q_W;
    localparam int ROB_W  = $clog2(ROB_SIZE + 1);
    localparam int WIDE   = Q_W + ROB_W;
    localparam logic [WIDE-1:0] ROB_K = WIDE'(ROB_SIZE);
    localparam q_t  BIG_BASE = q_t'(Q_ONE / q_t'(BIG_W));

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_RATIO,
        ST_SECOND
    } est_state_e;

    typedef struct packed {
        est_state_e        state;
        logic              dir;
        q_t                mem_in;
        q_t                mpi;
        q_t                mlp_in;
        q_t                dd;
        logic [HIST_W-1:0] hist;
        q_t                ipc;
        q_t                mem_est;
        logic              div_go;
        q_t                div_num;
        q_t                div_den;
        logic              done;
        q_t                base_o;
        q_t                mem_o;
        q_t                tot_o;
    } est_st_t;

    est_st_t st_d, st_q;

    logic            job_dir;
    logic            div_done;
    q_t              div_quot;
    q_t              ipc_w;
    logic [WIDE-1:0] mlp_big_w;
    q_t              mlp_big;
    q_t              mlp_small;
    q_t              fin_base;
    q_t              fin_mem;

    assign job_dir = st_q.dir;

    cce_issue_model #(
        .SMALL_W (SMALL_W)
    ) u_issue (
        .hist (st_q.hist),
        .ipc  (ipc_w)
    );

    cce_divider u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_q.div_go),
        .num   (st_q.div_num),
        .den   (st_q.div_den),
        .done  (div_done),
        .quot  (div_quot)
    );

    assign mlp_big_w = WIDE'(st_q.mpi) * ROB_K;
    assign mlp_big   = (|mlp_big_w[WIDE-1:Q_W]) ? Q_MAX : mlp_big_w[Q_W-1:0];
    assign mlp_small = q_mul_sat(st_q.mpi, st_q.dd);
    assign fin_base  = job_dir ? div_quot : BIG_BASE;
    assign fin_mem   = job_dir ? st_q.mem_est : div_quot;

    always_comb begin
        st_d        = st_q;
        st_d.div_go = 1'b0;
        st_d.done   = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.dir    = est_small;
                    st_d.mem_in = mem_cpi;
                    st_d.mpi    = miss_per_instr;
                    st_d.mlp_in = mlp_meas;
                    st_d.dd     = dep_dist;
                    st_d.hist   = dep_hist;
                    st_d.state  = ST_PREP;
                end
            end
            ST_PREP: begin
                st_d.ipc     = ipc_w;
                st_d.div_go  = 1'b1;
                st_d.div_num = job_dir ? st_q.mlp_in : mlp_big;
                st_d.div_den = job_dir ? mlp_small : st_q.mlp_in;
                st_d.state   = ST_RATIO;
            end
            ST_RATIO: begin
                if (div_done) begin
                    st_d.div_go = 1'b1;
                    if (job_dir) begin
                        st_d.mem_est = q_mul_sat(st_q.mem_in, div_quot);
                        st_d.div_num = Q_ONE;
                        st_d.div_den = st_q.ipc;
                    end else begin
                        st_d.div_num = st_q.mem_in;
                        st_d.div_den = div_quot;
                    end
                    st_d.state = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (div_done) begin
                    st_d.base_o = fin_base;
                    st_d.mem_o  = fin_mem;
                    st_d.tot_o  = q_add_sat(fin_base, fin_mem);
                    st_d.done   = 1'b1;
                    st_d.state  = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy          = (st_q.state != ST_IDLE);
    assign done          = st_q.done;
    assign est_base_cpi  = st_q.base_o;
    assign est_mem_cpi   = st_q.mem_o;
    assign est_total_cpi = st_q.tot_o;

endmodule

// File: rtl/cce_estimator_chk.sv
module cce_estimator_chk #(
    parameter int BIG_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        job_dir,
    input logic [15:0] est_base_cpi,
    input logic [15:0] est_mem_cpi,
    input logic [15:0] est_total_cpi
);
    localparam logic [15:0] BASE_K = 16'(256 / BIG_W);

    logic [16:0] sum_chk;
    logic [15:0] sum_sat;
    assign sum_chk = {1'b0, est_base_cpi} + {1'b0, est_mem_cpi};
    assign sum_sat = sum_chk[16] ? 16'hFFFF : sum_chk[15:0];

    // R2: completion lasts a single cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: completion coincides with return to idle
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: an idle start is always taken
    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: estimates move only with done
    p_hold_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(est_base_cpi) && $stable(est_mem_cpi) && $stable(est_total_cpi)));

    // R3: big-core base estimate is set by the issue width
    p_big_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !job_dir) |-> (est_base_cpi == BASE_K));

    // R9: total is the saturated sum of the parts
    p_total_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (est_total_cpi == sum_sat));

endmodule

bind cce_estimator cce_estimator_chk #(
    .BIG_W (BIG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .job_dir       (job_dir),
    .est_base_cpi  (est_base_cpi),
    .est_mem_cpi   (est_mem_cpi),
    .est_total_cpi (est_total_cpi)
);

// File: tb/tb_cce_estimator.sv
module tb_cce_estimator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        est_small = 1'b0;
    logic [15:0] mem_cpi = '0;
    logic [15:0] miss_per_instr = '0;
    logic [15:0] mlp_meas = '0;
    logic [15:0] dep_dist = '0;
    logic [47:0] dep_hist = '0;
    logic        busy, done;
    logic [15:0] est_base_cpi, est_mem_cpi, est_total_cpi;

    always #10 clk = ~clk;  // 50 MHz

    cce_estimator dut (
        .clk (clk), .rst_n (rst_n), .start (start), .est_small (est_small),
        .mem_cpi (mem_cpi), .miss_per_instr (miss_per_instr), .mlp_meas (mlp_meas),
        .dep_dist (dep_dist), .dep_hist (dep_hist), .busy (busy), .done (done),
        .est_base_cpi (est_base_cpi), .est_mem_cpi (est_mem_cpi),
        .est_total_cpi (est_total_cpi)
    );

    int errors = 0;
    int checks = 0;

    typedef struct packed {
        logic        dir;
        logic [15:0] mem;
        logic [15:0] mpi;
        logic [15:0] mlp;
        logic [15:0] dd;
        logic [47:0] hist;
        logic [15:0] e_base;
        logic [15:0] e_mem;
        logic [15:0] e_tot;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0400, 16'h0010, 16'h0100, 16'h0000, 48'h0, 16'h0040, 16'h0080, 16'h00C0, "R4 "},
        '{1'b0, 16'h0300, 16'h0004, 16'h0200, 16'h0000, 48'h0, 16'h0040, 16'h0300, 16'h0340, "R3 "},
        '{1'b1, 16'h0100, 16'h0040, 16'h0200, 16'h0200, 48'h0, 16'h0040, 16'h0400, 16'h0440, "R6 "},
        '{1'b1, 16'h0280, 16'h0080, 16'h0080, 16'h0100, 48'h0000_0000_0100, 16'h0100, 16'h0280, 16'h0380, "R5 "},
        '{1'b1, 16'h0200, 16'h0100, 16'h0180, 16'h0100, 48'h0020_0040_0080, 16'h009C, 16'h0300, 16'h039C, "R6 "},
        '{1'b1, 16'h0100, 16'h0100, 16'h0100, 16'h0100, 48'h0000_00C0_00C0, 16'h00AA, 16'h0100, 16'h01AA, "R7 "},
        '{1'b1, 16'h0200, 16'h0000, 16'h0100, 16'h0200, 48'h0, 16'h0040, 16'hFFFF, 16'hFFFF, "R8 "},
        '{1'b0, 16'h0400, 16'h0010, 16'h0000, 16'h0000, 48'h0, 16'h0040, 16'h0004, 16'h0044, "R8 "},
        '{1'b0, 16'h0100, 16'h0000, 16'h0100, 16'h0000, 48'h0, 16'h0040, 16'hFFFF, 16'hFFFF, "R8 "},
        '{1'b0, 16'h0100, 16'h0200, 16'h0100, 16'h0000, 48'h0, 16'h0040, 16'h0001, 16'h0041, "R4 "},
        '{1'b1, 16'hFFC0, 16'h0100, 16'h0100, 16'h0100, 48'h0000_0000_0100, 16'h0100, 16'hFFC0, 16'hFFFF, "R9 "}
    };

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        est_small      = v.dir;
        mem_cpi        = v.mem;
        miss_per_instr = v.mpi;
        mlp_meas       = v.mlp;
        dep_dist       = v.dd;
        dep_hist       = v.hist;
    endtask

    task automatic scramble();
        est_small      = ~est_small;
        mem_cpi        = 16'h1234;
        miss_per_instr = 16'h0777;
        mlp_meas       = 16'h0033;
        dep_dist       = 16'h0500;
        dep_hist       = 48'h0011_0022_0033;
    endtask

    // waits for done, sampling at negedge; returns 1 when seen
    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
    endtask

    task automatic run_vec(input vec_t v);
        bit seen;
        string t;
        t = string'(v.tag);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scramble();  // R2: inputs after capture must not matter
        check("R2", "busy after start", {15'b0, busy}, 16'h0001);
        wait_done(seen);
        check("R2", "done seen", {15'b0, seen}, 16'h0001);
        check(t, "base", est_base_cpi, v.e_base);
        check(t, "mem", est_mem_cpi, v.e_mem);
        check(t, "total", est_total_cpi, v.e_tot);
        @(negedge clk);
        check("R2", "done one cycle", {15'b0, done}, 16'h0000);
    endtask

    initial begin
        bit seen;
        int extra;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", {15'b0, busy}, 16'h0);
        check("R1", "total in reset", est_total_cpi, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", {15'b0, done}, 16'h0);
        check("R1", "base after reset", est_base_cpi, 16'h0);
        check("R1", "mem after reset", est_mem_cpi, 16'h0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2: start while busy is ignored
        @(negedge clk);
        drive(VECS[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        drive(VECS[1]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check("R2", "busy start done", {15'b0, seen}, 16'h0001);
        check("R2", "busy start mem kept", est_mem_cpi, VECS[0].e_mem);
        check("R2", "busy start total kept", est_total_cpi, VECS[0].e_tot);
        extra = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R2", "no second job", 16'(extra), 16'h0);
        check("R2", "outputs held", est_total_cpi, VECS[0].e_tot);

        // R1: reset during a job
        @(negedge clk);
        drive(VECS[4]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after mid reset", {15'b0, busy}, 16'h0);
        check("R1", "total after mid reset", est_total_cpi, 16'h0);
        extra = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R1", "discarded job silent", 16'(extra), 16'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule